// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Access Timing Sequencer

This block times a single asynchronous access to an external SRAM, ROM or NOR flash device. A host raises a one-cycle start strobe together with a read/write flag and a multiplexed-bus flag. The block then walks through an address setup phase, an address hold phase when the bus is multiplexed, and a data phase. After a multiplexed read it also inserts an idle turnaround gap. It ends each access with a one-cycle done pulse. Every phase length is counted in system clock cycles and comes from a field of a 32-bit timing word.

The timing word sits in a register that the host writes through a write strobe. At reset it holds the slowest setting. The fields are captured when an access is accepted, so a write made during an access applies only to later ones. On the memory side the block drives active-low chip select, output enable, write enable and address-latch strobes. It also presents a two-bit access-mode code that is captured at the same moment as the timing fields.

Top module: `amt_seq`

## Requirements
- R1: After reset all memory strobes are high, done_o is 0, mode_o is 0 and the timing word holds 0x0FFFFFFF, so the first access uses 16 setup, 16 hold, 256 data and 16 turnaround cycles.
- R2: An accepted start is followed, from the next cycle, by a setup phase of word[3:0]+1 cycles with cs_n_o low; ale_n_o is low for the whole setup phase when mux_i was 1 at the start, and it is never low otherwise.
- R3: When mux_i was 1, a hold phase of word[7:4]+1 cycles follows setup, with cs_n_o low and the other strobes high; a code of 0 gives 2 cycles. Without mux_i there is no hold phase.
- R4: The data phase lasts word[15:8]+1 cycles, and a code of 0 gives 2 cycles. cs_n_o is low throughout, oe_n_o is low on a read (rd_i=1) and we_n_o is low on a write. The two are never low together.
- R5: Only after a read with mux_i=1, a turnaround of word[19:16]+1 cycles with every strobe high follows the data phase. Writes and non-multiplexed reads have no turnaround.
- R6: done_o is high for exactly one cycle right after the last phase, with every strobe high. The block is idle in the following cycle.
- R7: A start that arrives while an access is running, including its done cycle, is ignored. A start held high continuously is accepted again in the first idle cycle.
- R8: mode_o takes word[29:28] when ext_en_i is 1 at acceptance, and 0 otherwise. It holds that value until the next accepted start.
- R9: A write with cfg_we_i=1 loads cfg_wdata_i into the timing word at that clock edge. An access uses the word held at its acceptance edge, so a write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing word write strobe |
| cfg_wdata_i | input | 32 | Timing word write data |
| start_i | input | 1 | Access request strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| mux_i | input | 1 | Multiplexed address/data bus |
| ext_en_i | input | 1 | Enables the access-mode field |
| done_o | output | 1 | One-cycle access completion pulse |
| mode_o | output | 2 | Access-mode code captured at start |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| ale_n_o | output | 1 | Address-latch strobe, active low |

## Verification
The strobes are decoded from the state register, so they change one cycle after the accepting edge and then follow the programmed phase lengths exactly. The done pulse comes in the cycle after the final phase counter reaches zero, and the mode code changes in the cycle after acceptance. At every accepted start the bench computes the whole per-cycle expected strobe pattern into a queue, using its own copy of the timing word. It compares one queue entry per clock at the falling edge, away from the edge where the design samples. A start counts as accepted only when the previous cycle's expectation was idle, and that is how ignored starts are modelled.

// File: rtl/amt_pkg.sv
package amt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HOLD  = 3'd2,
    ST_DATA  = 3'd3,
    ST_TURN  = 3'd4,
    ST_DONE  = 3'd5
  } amt_state_e;

  function automatic int unsigned amt_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/amt_cfg_reg.sv
module amt_cfg_reg #(
  parameter int unsigned        TW      = 32,
  parameter logic [TW-1:0]      RST_VAL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/amt_field_dec.sv
module amt_field_dec #(
  parameter int unsigned TW     = 32,
  parameter int unsigned AS_LSB = 0,
  parameter int unsigned AS_W   = 4,
  parameter int unsigned AH_LSB = 4,
  parameter int unsigned AH_W   = 4,
  parameter int unsigned DS_LSB = 8,
  parameter int unsigned DS_W   = 8,
  parameter int unsigned BT_LSB = 16,
  parameter int unsigned BT_W   = 4,
  parameter int unsigned MD_LSB = 28,
  parameter int unsigned MD_W   = 2,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [TW-1:0]    word_i,
  input  logic             ext_en_i,
  output logic [CNT_W-1:0] as_ld_o,
  output logic [CNT_W-1:0] ah_ld_o,
  output logic [CNT_W-1:0] ds_ld_o,
  output logic [CNT_W-1:0] bt_ld_o,
  output logic [MD_W-1:0]  mode_o
);
  localparam logic [TW-1:0] USED_MASK =
      (((TW'(1) << AS_W) - TW'(1)) << AS_LSB) |
      (((TW'(1) << AH_W) - TW'(1)) << AH_LSB) |
      (((TW'(1) << DS_W) - TW'(1)) << DS_LSB) |
      (((TW'(1) << BT_W) - TW'(1)) << BT_LSB) |
      (((TW'(1) << MD_W) - TW'(1)) << MD_LSB);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [AS_W-1:0] as_raw;
  logic [AH_W-1:0] ah_raw;
  logic [DS_W-1:0] ds_raw;
  logic [BT_W-1:0] bt_raw;
  logic            unused_bits;

  assign as_raw = word_i[AS_LSB +: AS_W];
  assign ah_raw = word_i[AH_LSB +: AH_W];
  assign ds_raw = word_i[DS_LSB +: DS_W];
  assign bt_raw = word_i[BT_LSB +: BT_W];
  assign unused_bits = ^(word_i & ~USED_MASK);

  // counter loads are cycles-1; reserved code 0 promoted to 1 (2 cycles)
  assign as_ld_o = CNT_W'(as_raw);
  assign bt_ld_o = CNT_W'(bt_raw);
  assign ah_ld_o = (ah_raw == '0) ? ONE : CNT_W'(ah_raw);
  assign ds_ld_o = (ds_raw == '0) ? ONE : CNT_W'(ds_raw);

  generate
    if (MD_W > 0) begin : g_mode
      assign mode_o = ext_en_i ? word_i[MD_LSB +: MD_W] : '0;
    end
  endgenerate
endmodule

// File: rtl/amt_fsm.sv
module amt_fsm
  import amt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             mux_i,
  input  logic [CNT_W-1:0] as_ld_i,
  input  logic [CNT_W-1:0] ah_ld_i,
  input  logic [CNT_W-1:0] ds_ld_i,
  input  logic [CNT_W-1:0] bt_ld_i,
  output amt_state_e       state_o,
  output logic             rd_o,
  output logic             mux_o,
  output logic             accept_o
);
  amt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ah_q, ds_q, bt_q;
  logic             rd_q, mux_q;
  logic             last;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last     = (cnt_q == '0);
  assign state_o  = state_q;
  assign rd_o     = rd_q;
  assign mux_o    = mux_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q - CNT_W'(1);
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = cnt_q;
        if (start_i) begin
          state_d = ST_SETUP;
          cnt_d   = as_ld_i;
        end
      end
      ST_SETUP: if (last) begin
        state_d = mux_q ? ST_HOLD : ST_DATA;
        cnt_d   = mux_q ? ah_q : ds_q;
      end
      ST_HOLD: if (last) begin
        state_d = ST_DATA;
        cnt_d   = ds_q;
      end
      ST_DATA: if (last) begin
        state_d = (rd_q && mux_q) ? ST_TURN : ST_DONE;
        cnt_d   = (rd_q && mux_q) ? bt_q : '0;
      end
      ST_TURN: if (last) begin
        state_d = ST_DONE;
        cnt_d   = '0;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // snapshot of the access parameters at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ah_q  <= '0;
      ds_q  <= '0;
      bt_q  <= '0;
      rd_q  <= 1'b0;
      mux_q <= 1'b0;
    end else if (accept_o) begin
      ah_q  <= ah_ld_i;
      ds_q  <= ds_ld_i;
      bt_q  <= bt_ld_i;
      rd_q  <= rd_i;
      mux_q <= mux_i;
    end
  end
endmodule

// File: rtl/amt_out_dec.sv
module amt_out_dec
  import amt_pkg::*;
(
  input  amt_state_e state_i,
  input  logic       rd_i,
  input  logic       mux_i,
  output logic       cs_n_o,
  output logic       oe_n_o,
  output logic       we_n_o,
  output logic       ale_n_o,
  output logic       done_o
);
  logic in_data;

  assign in_data = (state_i == ST_DATA);
  assign cs_n_o  = !((state_i == ST_SETUP) || (state_i == ST_HOLD) || in_data);
  assign ale_n_o = !((state_i == ST_SETUP) && mux_i);
  assign oe_n_o  = !(in_data && rd_i);
  assign we_n_o  = !(in_data && !rd_i);
  assign done_o  = (state_i == ST_DONE);
endmodule

// File: rtl/amt_seq.sv
module amt_seq
  import amt_pkg::*;
#(
  parameter int unsigned   TW        = 32,
  parameter logic [TW-1:0] TIMING_RST = 32'h0FFF_FFFF,
  parameter int unsigned   AS_LSB    = 0,
  parameter int unsigned   AS_W      = 4,
  parameter int unsigned   AH_LSB    = 4,
  parameter int unsigned   AH_W      = 4,
  parameter int unsigned   DS_LSB    = 8,
  parameter int unsigned   DS_W      = 8,
  parameter int unsigned   BT_LSB    = 16,
  parameter int unsigned   BT_W      = 4,
  parameter int unsigned   MD_LSB    = 28,
  parameter int unsigned   MD_W      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [TW-1:0]   cfg_wdata_i,
  input  logic            start_i,
  input  logic            rd_i,
  input  logic            mux_i,
  input  logic            ext_en_i,
  output logic            done_o,
  output logic [MD_W-1:0] mode_o,
  output logic            cs_n_o,
  output logic            oe_n_o,
  output logic            we_n_o,
  output logic            ale_n_o
);
  localparam int unsigned CNT_W = amt_max(amt_max(AS_W, AH_W), amt_max(DS_W, BT_W));

  logic [TW-1:0]    word;
  logic [CNT_W-1:0] as_ld, ah_ld, ds_ld, bt_ld;
  logic [MD_W-1:0]  mode_d, mode_q;
  amt_state_e       state;
  logic             rd_s, mux_s, accept;

  amt_cfg_reg #(.TW(TW), .RST_VAL(TIMING_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (word)
  );

  amt_field_dec #(
    .TW(TW), .AS_LSB(AS_LSB), .AS_W(AS_W), .AH_LSB(AH_LSB), .AH_W(AH_W),
    .DS_LSB(DS_LSB), .DS_W(DS_W), .BT_LSB(BT_LSB), .BT_W(BT_W),
    .MD_LSB(MD_LSB), .MD_W(MD_W), .CNT_W(CNT_W)
  ) u_dec (
    .word_i   (word),
    .ext_en_i (ext_en_i),
    .as_ld_o  (as_ld),
    .ah_ld_o  (ah_ld),
    .ds_ld_o  (ds_ld),
    .bt_ld_o  (bt_ld),
    .mode_o   (mode_d)
  );

  amt_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rd_i     (rd_i),
    .mux_i    (mux_i),
    .as_ld_i  (as_ld),
    .ah_ld_i  (ah_ld),
    .ds_ld_i  (ds_ld),
    .bt_ld_i  (bt_ld),
    .state_o  (state),
    .rd_o     (rd_s),
    .mux_o    (mux_s),
    .accept_o (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= '0;
    else if (accept) mode_q <= mode_d;
  end
  assign mode_o = mode_q;

  amt_out_dec u_out (
    .state_i (state),
    .rd_i    (rd_s),
    .mux_i   (mux_s),
    .cs_n_o  (cs_n_o),
    .oe_n_o  (oe_n_o),
    .we_n_o  (we_n_o),
    .ale_n_o (ale_n_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/amt_seq_chk.sv
module amt_seq_chk #(
  parameter int unsigned MD_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_n_i,
  input logic            oe_n_i,
  input logic            we_n_i,
  input logic            ale_n_i,
  input logic            done_i,
  input logic [MD_W-1:0] mode_i
);
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_i && !we_n_i)); // R4

  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_i || !we_n_i || !ale_n_i) |-> !cs_n_i); // R2

  AST_ALE_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_n_i |-> (oe_n_i && we_n_i)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R6

  AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cs_n_i && oe_n_i && we_n_i && ale_n_i)); // R6

  AST_NO_RESTART_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cs_n_i); // R7

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !$past(cs_n_i)) |-> $stable(mode_i)); // R8
endmodule

bind amt_seq amt_seq_chk #(.MD_W(MD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_i  (cs_n_o),
  .oe_n_i  (oe_n_o),
  .we_n_i  (we_n_o),
  .ale_n_i (ale_n_o),
  .done_i  (done_o),
  .mode_i  (mode_o)
);

// File: tb/sim_amt_seq.sv
`timescale 1ns/1ps
module sim_amt_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0, rd_i = 1'b0, mux_i = 1'b0, ext_en_i = 1'b0;
  logic        done_o, cs_n_o, oe_n_o, we_n_o, ale_n_o;
  logic [1:0]  mode_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // expected {cs, oe, we, ale, done}, active high
  logic [4:0]  q_exp[$];
  string       q_tag[$];
  logic [31:0] m_word = 32'h0FFF_FFFF;
  logic [1:0]  m_mode = 2'b00;

  always #5 clk_i = ~clk_i;

  amt_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .start_i(start_i), .rd_i(rd_i), .mux_i(mux_i), .ext_en_i(ext_en_i),
    .done_o(done_o), .mode_o(mode_o), .cs_n_o(cs_n_o), .oe_n_o(oe_n_o),
    .we_n_o(we_n_o), .ale_n_o(ale_n_o)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin : watchdog
    while (cyc < 20000) @(posedge clk_i) cyc++;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=%0d expected<20000 cycles", cyc);
    summary();
    $finish;
  end

  task automatic push_n(int n, logic [4:0] v, string tag);
    for (int i = 0; i < n; i++) begin
      q_exp.push_back(v);
      q_tag.push_back(tag);
    end
  endtask

  task automatic push_access(logic rd, logic mx, logic [31:0] w, string note);
    int n_as, n_ah, n_ds, n_bt;
    n_as = int'(w[3:0]) + 1;
    n_ah = ((w[7:4] == 4'd0) ? 1 : int'(w[7:4])) + 1;
    n_ds = ((w[15:8] == 8'd0) ? 1 : int'(w[15:8])) + 1;
    n_bt = int'(w[19:16]) + 1;
    push_n(n_as, {1'b1, 1'b0, 1'b0, mx, 1'b0}, {"R2 setup", note});
    if (mx) push_n(n_ah, 5'b10000, {"R3 hold", note});
    push_n(n_ds, {1'b1, rd, !rd, 1'b0, 1'b0}, {"R4 data", note});
    if (rd && mx) push_n(n_bt, 5'b00000, {"R5 turnaround", note});
    push_n(1, 5'b00001, {"R6 done", note});
  endtask

  // one clock: check this cycle's outputs, then drive the next edge's inputs
  task automatic step(logic st, logic rd, logic mx, logic ex,
                      logic cw, logic [31:0] cd, string note);
    logic [4:0] act, exp_v;
    string tag;
    logic idle_now;
    @(negedge clk_i);
    act = {!cs_n_o, !oe_n_o, !we_n_o, !ale_n_o, done_o};
    idle_now = (q_exp.size() == 0);
    if (idle_now) begin
      exp_v = 5'b00000;
      tag = "R7 idle";
    end else begin
      exp_v = q_exp.pop_front();
      tag = q_tag.pop_front();
    end
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s: strobes actual=%b expected=%b at t=%0t", tag, act, exp_v, $time);
    end
    checks++;
    if (mode_o !== m_mode) begin
      failures++;
      $display("FAIL R8 mode: actual=%b expected=%b at t=%0t", mode_o, m_mode, $time);
    end
    start_i = st; rd_i = rd; mux_i = mx; ext_en_i = ex;
    cfg_we_i = cw; cfg_wdata_i = cd;
    if (st && idle_now) begin
      push_access(rd, mx, m_word, note);
      m_mode = ex ? m_word[29:28] : 2'b00;
    end
    if (cw) m_word = cd;
  endtask

  task automatic idle_until_done();
    while (q_exp.size() != 0) step(0, 0, 0, 0, 0, '0, "");
    step(0, 0, 0, 0, 0, '0, "");
  endtask

  task automatic access(logic rd, logic mx, logic ex, string note);
    step(1, rd, mx, ex, 0, '0, note);
    idle_until_done();
  endtask

  task automatic cfg(logic [31:0] w);
    step(0, 0, 0, 0, 1, w, " (R9)");
  endtask

  initial begin : stim
    #2;
    checks++; // R1 reset state
    if ({cs_n_o, oe_n_o, we_n_o, ale_n_o, done_o, mode_o} !== 7'b1111000) begin
      failures++;
      $display("FAIL R1 reset: actual=%b expected=1111000",
               {cs_n_o, oe_n_o, we_n_o, ale_n_o, done_o, mode_o});
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, '0, "");
    // R1: reset word gives longest phases, multiplexed read
    access(1, 1, 1, " (R1 reset word)");
    // R3 R4: reserved codes 0 clamp to 2 cycles
    cfg(32'h0000_0000);
    access(0, 0, 0, " (R4 clamp)");
    access(1, 1, 0, " (R3 clamp)");
    // R5: no turnaround for non-mux read or mux write; R8 mode from field
    cfg(32'h2003_0A21);
    access(1, 0, 1, " (R5 nonmux read)");
    access(0, 1, 1, " (R5 mux write)");
    access(1, 1, 1, " (R5 mux read)");
    // R8: ext_en low forces mode 0
    cfg(32'h3000_0102);
    access(0, 1, 0, " (R8 ext off)");
    access(1, 0, 1, " (R8 ext on)");
    // R7: start held high, ignored while busy, reaccepted when idle
    for (int i = 0; i < 40; i++) step(1, i[0], i[1], 1, 0, '0, " (R7 held start)");
    idle_until_done();
    // R9: write during access affects only the next one
    step(1, 1, 1, 1, 0, '0, " (R9 old word)");
    step(0, 0, 0, 0, 1, 32'h1001_0310, "");
    idle_until_done();
    access(1, 1, 1, " (R9 new word)");
    access(0, 0, 1, " (R9 new word write)");
    repeat (3) step(0, 0, 0, 0, 0, '0, "");
    summary();
    $finish;
  end
endmodule